// File: doc/BRIEF.md
# Block-Cipher Register Window Front End

This block is the register-side front end of a block-cipher engine. A bus or DMA master stores key words, IV or counter words and a mode word through a simple write channel. It then streams plaintext or ciphertext words into an input window that indexes itself. When a whole block has been gathered, the front end launches the cipher core with a one-cycle start pulse and holds the block steady on a 128-bit bus. When the core reports done, the front end captures the 128-bit result into an output window. The master drains that window with repeated reads of one address.

Two request lines pace a DMA engine. `in_req` says the input window will take data now. `out_req` says a finished block is waiting to be read. The chaining mode sets how many accesses make up a block, and whether each access carries a word, a halfword or a byte. The last-result mode turns the unit into a checksum accumulator: every result overwrites the output window, `out_req` stays low, and only the final result is read out at the end.

Back-pressure rules:
- The write channel completes when `wr_valid` and `wr_ready` are both high at a rising edge.
- `wr_ready` depends only on the address. Writes to the input window follow `in_req`. Writes to any other address are always taken.
- The read channel never stalls (`rd_ready` is tied high). `rd_data` is valid in the same cycle as `rd_valid`. A read of the output window moves its index on at that edge.

Top module: `cipher_window_fe`

## Requirements
- R1: Key word k (write address 1+k, k=0..7) appears on `core_key[32k+31:32k]`. Words beyond the selected key length are driven as zero. Key length field = mode bits [6:5]: 0 selects 4 words, 1 selects 6 words, 2 or 3 selects 8 words.
- R2: IV word i (write address 9+i, i=0..3) appears on `core_iv[32i+31:32i]` in every chaining mode except ECB. In ECB, `core_iv` is all zero. Chain field = mode bits [3:0]: 0 ECB, 1 CBC, 2 OFB, 3 CTR, 4 CFB-128, 5 CFB-64, 6 CFB-32, 7 CFB-16, 8 CFB-8.
- R3: Successive writes to address 13 fill block word 0, 1, 2, ... in turn, placing word i at `core_din[32i+31:32i]`. After the last word of a block the index wraps to word 0.
- R4: In CFB-8 each input access carries one byte, taken from `wr_data[7:0]`. In CFB-16 it carries one halfword, taken from `wr_data[15:0]`. The unused bits of the access are ignored, and `core_din` above the block is zero. Output reads in those modes return the byte or halfword zero-extended.
- R5: A block is 4 accesses in ECB, CBC, OFB, CTR and CFB-128, 2 in CFB-64, and 1 in CFB-32, CFB-16 and CFB-8. `core_start` is high for exactly one cycle, in the cycle after the write that completes a block. No other write starts the core.
- R6: `in_req`, and `wr_ready` for address 13, are low from the cycle after a block completes until `core_done`. When last-result mode is off, they also stay low while a finished block is waiting to be read.
- R7: With last-result mode off, `out_req` rises in the cycle after `core_done` and falls after the last word of the block has been read from address 14. Output reads return result word i from `core_dout[32i+31:32i]` in index order and wrap to word 0.
- R8: With last-result mode (mode bit 4) on, `out_req` stays low and `in_req` is not held back by unread results. The output window holds the result of the most recent block.
- R9: A write to the mode register (address 0) resets both window indices to word 0 and clears a pending output-ready state. The mode register reads back at address 0 in bits [6:0].
- R10: After reset, `in_req` is 1, `out_req` is 0, `core_start` is 0 and the mode register reads 0 (ECB, 4-word key, last-result off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted when high with `wr_valid` |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Always high; reads never stall |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Read data, same cycle as `rd_valid` |
| in_req | output | 1 | Input window can take data |
| out_req | output | 1 | Finished block waiting in the output window |
| core_start | output | 1 | One-cycle launch pulse to the cipher core |
| core_chain | output | 4 | Chaining mode code for the core |
| core_key_len | output | 2 | Key length code for the core |
| core_key | output | 32*KEY_WORDS | Key words, unused words zero |
| core_iv | output | BLK_W | IV or counter, zero in ECB |
| core_din | output | BLK_W | Gathered input block |
| core_done | input | 1 | Core has finished the block |
| core_dout | input | BLK_W | Core result, valid with `core_done` |

## Verification
The bench targets the places where block length and access size change with the mode. A 2-access CFB-64 block, and single byte and halfword blocks carrying junk in their upper bits, expose a design that launches on the wrong count or leaks unused bits into `core_din`. Output-request timing is checked on the exact cycle after done, and the bench confirms that the request drops only after the last read. A design off by one in the output index would hold the request too long or return words out of order. A mode write in the middle of a block must throw away the partial words, or the next block is scrambled. Last-result mode runs two blocks without reads, so a design that still asks for output, or that blocks input on unread data, stalls or raises `out_req`.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  localparam logic [3:0] A_MODE = 4'd0;
  localparam logic [3:0] A_KEY0 = 4'd1;
  localparam logic [3:0] A_IV0  = 4'd9;
  localparam logic [3:0] A_IN   = 4'd13;
  localparam logic [3:0] A_OUT  = 4'd14;

  typedef enum logic [3:0] {
    CM_ECB    = 4'd0,
    CM_CBC    = 4'd1,
    CM_OFB    = 4'd2,
    CM_CTR    = 4'd3,
    CM_CFB128 = 4'd4,
    CM_CFB64  = 4'd5,
    CM_CFB32  = 4'd6,
    CM_CFB16  = 4'd7,
    CM_CFB8   = 4'd8
  } chain_e;

  typedef enum logic [1:0] {
    XS_WORD = 2'd0,
    XS_HALF = 2'd1,
    XS_BYTE = 2'd2
  } xfer_e;

  typedef struct packed {
    logic [1:0] klen;
    logic       lod;
    chain_e     chain;
  } mode_t;

  function automatic logic [2:0] blk_words(input chain_e c);
    case (c)
      CM_CFB64:                   return 3'd2;
      CM_CFB32, CM_CFB16, CM_CFB8: return 3'd1;
      default:                    return 3'd4;
    endcase
  endfunction

  function automatic xfer_e xfer_of(input chain_e c);
    case (c)
      CM_CFB16: return XS_HALF;
      CM_CFB8:  return XS_BYTE;
      default:  return XS_WORD;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input xfer_e x, input logic [31:0] d);
    case (x)
      XS_HALF: return {16'd0, d[15:0]};
      XS_BYTE: return {24'd0, d[7:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [3:0] key_words(input logic [1:0] k);
    case (k)
      2'd0:    return 4'd4;
      2'd1:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/cwf_key_iv_regs.sv
module cwf_key_iv_regs
  import cwf_pkg::*;
#(
  parameter int KEY_WORDS = 8,
  parameter int IV_WORDS  = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [31:0]              wr_data,
  input  logic [1:0]               klen,
  input  chain_e                   chain,
  output logic [32*KEY_WORDS-1:0]  core_key,
  output logic [32*IV_WORDS-1:0]   core_iv,
  output logic [32*IV_WORDS-1:0]   iv_raw
);

  logic [KEY_WORDS-1:0][31:0] key_q;
  logic [IV_WORDS-1:0][31:0]  iv_q;
  logic [3:0]                 kw_used;

  assign kw_used = key_words(klen);

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                            key_q[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(A_KEY0) + ADDR_W'(g)) key_q[g] <= wr_data;
    end
    assign core_key[32*g +: 32] = (4'(g) < kw_used) ? key_q[g] : 32'd0;
  end

  for (genvar g = 0; g < IV_WORDS; g++) begin : g_iv
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                           iv_q[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(A_IV0) + ADDR_W'(g)) iv_q[g] <= wr_data;
    end
    assign iv_raw[32*g +: 32]  = iv_q[g];
  end

  assign core_iv = (chain == CM_ECB) ? '0 : iv_raw;

endmodule

// File: rtl/cwf_in_window.sv
module cwf_in_window
  import cwf_pkg::*;
#(
  parameter int BLK_WORDS = 4,
  localparam int IDX_W    = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   fire,
  input  logic [31:0]            wr_data,
  input  chain_e                 chain,
  input  logic                   core_done,
  input  logic                   blocked,
  output logic                   in_req,
  output logic                   busy,
  output logic                   core_start,
  output logic [32*BLK_WORDS-1:0] core_din
);

  logic [BLK_WORDS-1:0][31:0] buf_q, buf_nxt;
  logic [IDX_W-1:0]           idx_q;
  logic [2:0]                 nwords;
  logic                       last;
  logic [31:0]                lane;

  assign nwords = blk_words(chain);
  assign last   = (3'(idx_q) + 3'd1) >= nwords;
  assign lane   = lane_mask(xfer_of(chain), wr_data);

  always_comb begin
    buf_nxt        = buf_q;
    buf_nxt[idx_q] = lane;
    for (int i = 0; i < BLK_WORDS; i++) begin
      if (3'(i) >= nwords) buf_nxt[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q      <= '0;
      idx_q      <= '0;
      busy       <= 1'b0;
      core_start <= 1'b0;
    end else begin
      core_start <= 1'b0;
      if (fire) begin
        buf_q <= buf_nxt;
        if (last) begin
          idx_q      <= '0;
          busy       <= 1'b1;
          core_start <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
      if (clr) idx_q <= '0;
      if (core_done && busy) busy <= 1'b0;
    end
  end

  assign core_din = buf_q;
  assign in_req   = !busy && !blocked;

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);                                          // R5
  AST_FIRE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !busy);                                                      // R6
  AST_IN_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (3'(idx_q) < nwords));                                                // R3
  AST_START_FOLLOWS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> $past(fire));                                          // R5

endmodule

// File: rtl/cwf_out_window.sv
module cwf_out_window
  import cwf_pkg::*;
#(
  parameter int BLK_WORDS = 4,
  localparam int IDX_W    = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    cap,
  input  logic [32*BLK_WORDS-1:0] res_in,
  input  chain_e                  chain,
  input  logic                    lod,
  input  logic                    rd_fire,
  output logic                    out_req,
  output logic                    blocked,
  output logic [31:0]             rd_word
);

  logic [BLK_WORDS-1:0][31:0] res_q;
  logic [IDX_W-1:0]           idx_q;
  logic                       pend_q;
  logic                       last;

  assign last = (3'(idx_q) + 3'd1) >= blk_words(chain);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      idx_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (rd_fire) begin
        idx_q <= last ? '0 : idx_q + 1'b1;
        if (last) pend_q <= 1'b0;
      end
      if (clr) begin
        idx_q  <= '0;
        pend_q <= 1'b0;
      end
      if (cap) begin
        res_q  <= res_in;
        idx_q  <= '0;
        pend_q <= 1'b1;
      end
    end
  end

  assign rd_word = lane_mask(xfer_of(chain), res_q[idx_q]);
  assign blocked = pend_q && !lod;
  assign out_req = pend_q && !lod;

  AST_PEND_AFTER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> pend_q);                                                      // R7
  AST_OUT_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (3'(idx_q) < blk_words(chain)));                                      // R7
  AST_CLR_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !cap) |=> !out_req);                                          // R9

endmodule

// File: rtl/cipher_window_fe.sv
module cipher_window_fe
  import cwf_pkg::*;
#(
  parameter int KEY_WORDS = 8,
  parameter int BLK_W     = 128,
  parameter int ADDR_W    = 4,
  localparam int BLK_WORDS = BLK_W / 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [31:0]             wr_data,
  input  logic                    rd_valid,
  output logic                    rd_ready,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [31:0]             rd_data,
  output logic                    in_req,
  output logic                    out_req,
  output logic                    core_start,
  output logic [3:0]              core_chain,
  output logic [1:0]              core_key_len,
  output logic [32*KEY_WORDS-1:0] core_key,
  output logic [BLK_W-1:0]        core_iv,
  output logic [BLK_W-1:0]        core_din,
  input  logic                    core_done,
  input  logic [BLK_W-1:0]        core_dout
);

  mode_t             mode_q;
  logic              wr_fire, mode_wr, in_fire, out_fire;
  logic              busy, blocked;
  logic [31:0]       out_word;
  logic [BLK_W-1:0]  iv_raw;
  logic [31:0]       iv_rd;

  assign wr_ready = (wr_addr == ADDR_W'(A_IN)) ? in_req : 1'b1;
  assign wr_fire  = wr_valid && wr_ready;
  assign mode_wr  = wr_fire && (wr_addr == ADDR_W'(A_MODE));
  assign in_fire  = wr_fire && (wr_addr == ADDR_W'(A_IN));
  assign rd_ready = 1'b1;
  assign out_fire = rd_valid && (rd_addr == ADDR_W'(A_OUT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= mode_t'(wr_data[6:0]);
  end

  assign core_chain   = mode_q.chain;
  assign core_key_len = mode_q.klen;

  cwf_key_iv_regs #(
    .KEY_WORDS (KEY_WORDS),
    .IV_WORDS  (BLK_WORDS),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_fire),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .klen     (mode_q.klen),
    .chain    (mode_q.chain),
    .core_key (core_key),
    .core_iv  (core_iv),
    .iv_raw   (iv_raw)
  );

  cwf_in_window #(.BLK_WORDS(BLK_WORDS)) u_in (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (mode_wr),
    .fire       (in_fire),
    .wr_data    (wr_data),
    .chain      (mode_q.chain),
    .core_done  (core_done),
    .blocked    (blocked),
    .in_req     (in_req),
    .busy       (busy),
    .core_start (core_start),
    .core_din   (core_din)
  );

  cwf_out_window #(.BLK_WORDS(BLK_WORDS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (mode_wr),
    .cap     (core_done && busy),
    .res_in  (core_dout),
    .chain   (mode_q.chain),
    .lod     (mode_q.lod),
    .rd_fire (out_fire),
    .out_req (out_req),
    .blocked (blocked),
    .rd_word (out_word)
  );

  always_comb begin
    iv_rd = '0;
    for (int i = 0; i < BLK_WORDS; i++) begin
      if (rd_addr == ADDR_W'(A_IV0) + ADDR_W'(i)) iv_rd = iv_raw[32*i +: 32];
    end
  end

  always_comb begin
    if (rd_addr == ADDR_W'(A_MODE))     rd_data = {25'd0, mode_q};
    else if (rd_addr == ADDR_W'(A_OUT)) rd_data = out_word;
    else                                rd_data = iv_rd;
  end

  AST_OUT_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |-> !in_req);                                                 // R6
  AST_LOD_NO_OUTREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.lod && $past(mode_q.lod)) |-> !out_req);                      // R8
  AST_NO_IN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !wr_ready || (wr_addr != ADDR_W'(A_IN)));              // R6

endmodule

// File: tb/cipher_window_fe_tb.sv
module cipher_window_fe_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [127:0] XMASK = {4{32'h5A5A_0F0F}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0, rd_valid = 1'b0;
  logic         wr_ready, rd_ready;
  logic [3:0]   wr_addr = '0, rd_addr = '0;
  logic [31:0]  wr_data = '0, rd_data;
  logic         in_req, out_req, core_start;
  logic [3:0]   core_chain;
  logic [1:0]   core_key_len;
  logic [255:0] core_key;
  logic [127:0] core_iv, core_din;
  logic         core_done = 1'b0;
  logic [127:0] core_dout = '0;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [127:0] exp_q[$];
  logic [127:0] lat = '0;
  int  cnt = 0;
  bit  done_d = 0;
  bit  lod_exp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cipher_window_fe u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_data(rd_data), .in_req(in_req), .out_req(out_req),
    .core_start(core_start), .core_chain(core_chain), .core_key_len(core_key_len),
    .core_key(core_key), .core_iv(core_iv), .core_din(core_din),
    .core_done(core_done), .core_dout(core_dout)
  );

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // core model and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_d)
        chk(out_req == !lod_exp, lod_exp ? "R8 out_req after done" : "R7 out_req after done",
            256'(out_req), 256'(!lod_exp));
      done_d = core_done;
      core_done = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          core_done = 1'b1;
          core_dout = lat ^ XMASK;
        end
      end
      if (core_start) begin
        if (exp_q.size() == 0) chk(0, "R5 unexpected start", 256'(core_din), 256'(0));
        else begin
          logic [127:0] e;
          e = exp_q.pop_front();
          chk(core_din == e, "R3 block contents", 256'(core_din), 256'(e));
        end
        lat = core_din;
        cnt = 3;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 256'(0), 256'(1));
    summary();
  end

  function automatic int nw(input logic [3:0] m);
    case (m)
      4'd5: return 2;
      4'd6, 4'd7, 4'd8: return 1;
      default: return 4;
    endcase
  endfunction

  function automatic logic [127:0] pack(input logic [3:0] m, input logic [31:0] w0, w1, w2, w3);
    case (m)
      4'd5: return {64'd0, w1, w0};
      4'd6: return {96'd0, w0};
      4'd7: return {112'd0, w0[15:0]};
      4'd8: return {120'd0, w0[7:0]};
      default: return {w3, w2, w1, w0};
    endcase
  endfunction

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    #1; d = rd_data;
    @(posedge clk); #1;
    rd_valid = 1'b0;
  endtask

  task automatic send_block(input logic [3:0] m, input logic [31:0] w0, w1, w2, w3);
    logic [31:0] w [4];
    w = '{w0, w1, w2, w3};
    exp_q.push_back(pack(m, w0, w1, w2, w3));
    for (int i = 0; i < nw(m); i++) bus_wr(4'd13, w[i]);
  endtask

  task automatic read_check(input int n, input logic [127:0] res, input string tag);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      bus_rd(4'd14, d);
      chk(d == res[32*i +: 32], tag, 256'(d), 256'(res[32*i +: 32]));
    end
  endtask

  initial begin
    logic [31:0] d;
    logic [255:0] kv;
    logic [127:0] ivv, blk;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(in_req == 1'b1, "R10 in_req", 256'(in_req), 256'(1));
    chk(out_req == 1'b0, "R10 out_req", 256'(out_req), 256'(0));
    chk(core_start == 1'b0, "R10 core_start", 256'(core_start), 256'(0));
    rst_n = 1'b1;
    bus_rd(4'd0, d);
    chk(d == 32'd0, "R10 mode reset", 256'(d), 256'(0));

    // R1 keys
    for (int k = 0; k < 8; k++) begin
      kv[32*k +: 32] = 32'h1000_0000 + 32'(k) * 32'h0101_1111;
      bus_wr(4'd1 + 4'(k), kv[32*k +: 32]);
    end
    #1;
    chk(core_key == {128'd0, kv[127:0]}, "R1 key 128", core_key, {128'd0, kv[127:0]});
    bus_wr(4'd0, 32'h20); #1;
    chk(core_key == {64'd0, kv[191:0]}, "R1 key 192", core_key, {64'd0, kv[191:0]});
    bus_wr(4'd0, 32'h40); #1;
    chk(core_key == kv, "R1 key 256", core_key, kv);

    // R2 IV
    for (int i = 0; i < 4; i++) begin
      ivv[32*i +: 32] = 32'hC0DE_0000 + 32'(i);
      bus_wr(4'd9 + 4'(i), ivv[32*i +: 32]);
    end
    #1;
    chk(core_iv == 128'd0, "R2 ECB iv zero", 256'(core_iv), 256'(0));
    bus_wr(4'd0, 32'h41); #1;
    chk(core_iv == ivv, "R2 CBC iv", 256'(core_iv), 256'(ivv));

    // CBC block A
    send_block(4'd1, 32'hA0A0_0001, 32'hA0A0_0002, 32'hA0A0_0003, 32'hA0A0_0004);
    wr_addr = 4'd13; #1;
    chk(in_req == 1'b0, "R6 in_req busy", 256'(in_req), 256'(0));
    chk(wr_ready == 1'b0, "R6 wr_ready busy", 256'(wr_ready), 256'(0));
    repeat (8) @(negedge clk);
    chk(in_req == 1'b0, "R6 in blocked by pending", 256'(in_req), 256'(0));
    blk = pack(4'd1, 32'hA0A0_0001, 32'hA0A0_0002, 32'hA0A0_0003, 32'hA0A0_0004) ^ XMASK;
    read_check(3, blk, "R7 out words");
    @(negedge clk);
    chk(out_req == 1'b1, "R7 out_req held", 256'(out_req), 256'(1));
    bus_rd(4'd14, d);
    chk(d == blk[127:96], "R7 out word 3", 256'(d), 256'(blk[127:96]));
    @(negedge clk);
    chk(out_req == 1'b0, "R7 out_req falls", 256'(out_req), 256'(0));
    chk(in_req == 1'b1, "R6 in_req returns", 256'(in_req), 256'(1));
    bus_rd(4'd14, d);
    chk(d == blk[31:0], "R7 out wrap", 256'(d), 256'(blk[31:0]));

    // second CBC block: input index wrapped (R3)
    send_block(4'd1, 32'hB1, 32'hB2, 32'hB3, 32'hB4);
    repeat (8) @(negedge clk);
    read_check(4, pack(4'd1, 32'hB1, 32'hB2, 32'hB3, 32'hB4) ^ XMASK, "R3 second block out");

    // R5 CFB-64
    bus_wr(4'd0, 32'h45);
    send_block(4'd5, 32'h6400_0001, 32'h6400_0002, 0, 0);
    repeat (8) @(negedge clk);
    read_check(2, pack(4'd5, 32'h6400_0001, 32'h6400_0002, 0, 0) ^ XMASK, "R5 CFB64 out");
    @(negedge clk);
    chk(out_req == 1'b0, "R5 CFB64 2-word drain", 256'(out_req), 256'(0));

    // R4 CFB-8 and CFB-16
    bus_wr(4'd0, 32'h48);
    send_block(4'd8, 32'hDEAD_BE37, 0, 0, 0);
    repeat (8) @(negedge clk);
    bus_rd(4'd14, d);
    chk(d == 32'h38, "R4 CFB8 out byte", 256'(d), 256'(32'h38));
    bus_wr(4'd0, 32'h47);
    send_block(4'd7, 32'h1234_ABCD, 0, 0, 0);
    repeat (8) @(negedge clk);
    bus_rd(4'd14, d);
    chk(d == 32'hA4C2, "R4 CFB16 out half", 256'(d), 256'(32'hA4C2));

    // R8 last-result mode
    lod_exp = 1;
    bus_wr(4'd0, 32'h51);
    send_block(4'd1, 32'hC1, 32'hC2, 32'hC3, 32'hC4);
    repeat (8) @(negedge clk);
    chk(in_req == 1'b1, "R8 in_req not blocked", 256'(in_req), 256'(1));
    chk(out_req == 1'b0, "R8 out_req low", 256'(out_req), 256'(0));
    send_block(4'd1, 32'hD1, 32'hD2, 32'hD3, 32'hD4);
    repeat (8) @(negedge clk);
    read_check(4, pack(4'd1, 32'hD1, 32'hD2, 32'hD3, 32'hD4) ^ XMASK, "R8 last result");

    // R9 mode write resets indices and pending
    lod_exp = 0;
    bus_wr(4'd0, 32'h41);
    bus_wr(4'd13, 32'hEEEE_0001);
    bus_wr(4'd13, 32'hEEEE_0002);
    bus_wr(4'd0, 32'h41);
    send_block(4'd1, 32'hE1, 32'hE2, 32'hE3, 32'hE4);
    repeat (8) @(negedge clk);
    chk(out_req == 1'b1, "R9 setup out_req", 256'(out_req), 256'(1));
    bus_wr(4'd0, 32'h41);
    @(negedge clk);
    chk(out_req == 1'b0, "R9 pending cleared", 256'(out_req), 256'(0));
    chk(in_req == 1'b1, "R9 in_req after clear", 256'(in_req), 256'(1));
    bus_rd(4'd0, d);
    chk(d == 32'h41, "R9 mode readback", 256'(d), 256'(32'h41));

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all blocks launched", 256'(exp_q.size()), 256'(0));
    summary();
  end
endmodule